// File: doc/BRIEF.md
# Per-Pin Interrupting GPIO Port

An eight-pin general-purpose I/O port in which every pin can act as its own interrupt source. Four configuration bits per pin (value, direction, alternate-select A and alternate-select B) choose one of several pin modes: push-pull output, plain input, level-sensitive interrupt, dual-edge interrupt or single-edge interrupt with selectable polarity. The value bit has a second job. In an interrupt mode it sets the active level or the active edge, and in output mode it is the driven value.

Each pin is sampled through a two-flop synchronizer. A third history flop provides the previous sample, which is used both for edge detection and for the two-sample qualification that level requests need. Edge events are held in a per-pin pending bit until software writes a one to that pin's bit in the clear register. Level requests follow the pin directly and cannot be cleared. Per-pin requests are OR-reduced into one port request, which a global enable input gates. In every interrupt mode the pad is never driven high.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is a plain input (B=0, A=0, direction=1, value=0): pad_oe is 0x00, pin_irq is 0x00 and irq is 0.
- R2: With B=0, a pin whose direction bit is 0 drives pad_out with its value bit and sets its pad_oe bit. A pin whose direction bit is 1 floats, and its pad activity never raises its pin_irq bit.
- R3: Level mode is B=1, A=1, direction=0. The pin's pin_irq bit rises after the third rising clock edge that follows a change of the pad to the level equal to its value bit.
- R4: In level mode, a pad that holds the matching level for only one clock period never raises pin_irq.
- R5: A level request falls after the second rising edge that follows the pad leaving the matching level. Writing the clear register has no effect on it.
- R6: Dual-edge mode is B=1, A=0, direction=0. Both a rising and a falling pad transition set the pin's pending bit, which is seen on pin_irq after the third rising edge. The value bit has no effect in this mode.
- R7: Single-edge mode is B=1, A=1, direction=1. A value bit of 1 makes only rising transitions set pending, and a value bit of 0 makes only falling transitions set pending.
- R8: An edge-mode pending bit stays set until a write with a 1 in that bit to the clear register (address 4). It is then 0 after that write's clock edge. A written 0 bit leaves it set.
- R9: When a new edge and a clear of the same pin occur at the same clock edge, the pending bit stays set.
- R10: Whenever B=1 (any interrupt mode, and the unused B=1, A=0, direction=1 setting), the pin has pad_oe=0 and pad_out=0. The unused setting raises no request.
- R11: irq equals irq_en AND the OR of pin_irq. Lowering irq_en clears no pending bit.
- R12: The write addresses are 0 value, 1 direction, 2 alternate A, 3 alternate B and 4 clear. A written register takes effect after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data, one bit per pin |
| irq_en | input | 1 | Global gate for the port request |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pin_irq | output | 8 | Per-pin interrupt requests |
| irq | output | 1 | Gated OR of all per-pin requests |

## Verification
A pad change becomes visible on pin_irq three rising edges later: two edges for the synchronizer, and a third for the history flop (level) or the pending flop (edge). Level release shows one edge earlier, after two. The bench changes pads and write strobes on falling edges and counts falling edges from that point. It checks that the output is still low after two of them and high after three, and it probes release at one and two. Register writes and clears are checked at the first falling edge after the sampling edge. The same-edge race is arranged by issuing the clear write exactly two falling edges after the pad change, so that the write and the edge are sampled at the same clock edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] REG_VALUE = 3'd0;
    localparam logic [REG_ADDR_W-1:0] REG_DIR   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] REG_ALTA  = 3'd2;
    localparam logic [REG_ADDR_W-1:0] REG_ALTB  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] REG_CLEAR = 3'd4;

    typedef enum logic [2:0] {
        PM_OUTPUT   = 3'd0,
        PM_INPUT    = 3'd1,
        PM_LEVEL    = 3'd2,
        PM_DUAL     = 3'd3,
        PM_SINGLE   = 3'd4,
        PM_RESERVED = 3'd5
    } pin_mode_e;

    typedef struct packed {
        logic meta;
        logic cur;
        logic prev;
    } sync_st_t;

    typedef struct packed {
        logic pending;
    } pin_st_t;

    function automatic pin_mode_e decode_mode(input logic alt_b,
                                              input logic alt_a,
                                              input logic dir);
        pin_mode_e m;
        if (!alt_b) begin
            m = dir ? PM_INPUT : PM_OUTPUT;
        end else if (!alt_a) begin
            m = dir ? PM_RESERVED : PM_DUAL;
        end else begin
            m = dir ? PM_SINGLE : PM_LEVEL;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic cur_o,
    output logic prev_o
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;

    AST_HISTORY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(cur_o))); // R3

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      value_o,
    output logic [WIDTH-1:0]      dir_o,
    output logic [WIDTH-1:0]      alt_a_o,
    output logic [WIDTH-1:0]      alt_b_o,
    output logic [WIDTH-1:0]      clear_o
);

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] alt_a;
        logic [WIDTH-1:0] alt_b;
    } cfg_st_t;

    cfg_st_t          cfg_d, cfg_q;
    logic [WIDTH-1:0] clear_d;

    always_comb begin
        cfg_d   = cfg_q;
        clear_d = '0;
        if (wr_en) begin
            case (wr_addr)
                REG_VALUE: cfg_d.value = wr_data;
                REG_DIR:   cfg_d.dir   = wr_data;
                REG_ALTA:  cfg_d.alt_a = wr_data;
                REG_ALTB:  cfg_d.alt_b = wr_data;
                REG_CLEAR: clear_d     = wr_data;
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.value <= '0;
            cfg_q.dir   <= '1;
            cfg_q.alt_a <= '0;
            cfg_q.alt_b <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign value_o = cfg_q.value;
    assign dir_o   = cfg_q.dir;
    assign alt_a_o = cfg_q.alt_a;
    assign alt_b_o = cfg_q.alt_b;
    assign clear_o = clear_d;

    AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIR) |=> (dir_o == $past(wr_data))); // R12

    AST_ALTB_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ALTB) |=> (alt_b_o == $past(wr_data))); // R12

    AST_CFG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value_o) && $stable(alt_b_o)); // R12

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic value_i,
    input  logic dir_i,
    input  logic alt_a_i,
    input  logic alt_b_i,
    input  logic clear_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic irq_o
);

    pin_st_t   st_d, st_q;
    pin_mode_e mode;
    logic      smp_cur;
    logic      smp_prev;
    logic      rise;
    logic      fall;
    logic      edge_hit;
    logic      level_req;
    logic      edge_mode;

    gpio_irq_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .cur_o   (smp_cur),
        .prev_o  (smp_prev)
    );

    always_comb begin
        mode      = decode_mode(alt_b_i, alt_a_i, dir_i);
        rise      = smp_cur & ~smp_prev;
        fall      = ~smp_cur & smp_prev;
        edge_mode = (mode == PM_DUAL) || (mode == PM_SINGLE);
        case (mode)
            PM_DUAL:   edge_hit = rise | fall;
            PM_SINGLE: edge_hit = value_i ? rise : fall;
            default:   edge_hit = 1'b0;
        endcase
        level_req = (mode == PM_LEVEL) && (smp_cur == value_i) && (smp_prev == value_i);
    end

    always_comb begin
        st_d         = st_q;
        st_d.pending = (st_q.pending & ~clear_i) | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (mode == PM_OUTPUT) begin
            pad_oe_o  = 1'b1;
            pad_out_o = value_i;
        end else begin
            pad_oe_o  = 1'b0;
            pad_out_o = 1'b0;
        end
        irq_o = edge_mode ? st_q.pending : level_req;
    end

    AST_EDGE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> st_q.pending); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && clear_i && !edge_hit) |=> !st_q.pending); // R8

    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && !clear_i) |=> st_q.pending); // R8

    AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        alt_b_i |-> (!pad_oe_o && !pad_out_o)); // R10

    AST_LEVEL_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (level_req && $stable(value_i)) |-> ($past(smp_cur) == value_i)); // R4

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]      wr_data,
    input  logic                  irq_en,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pin_irq,
    output logic                  irq
);

    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] alt_a_q;
    logic [WIDTH-1:0] alt_b_q;
    logic [WIDTH-1:0] clear_d;

    gpio_irq_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .value_o (value_q),
        .dir_o   (dir_q),
        .alt_a_o (alt_a_q),
        .alt_b_o (alt_b_q),
        .clear_o (clear_d)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pad_i     (pad_in[i]),
            .value_i   (value_q[i]),
            .dir_i     (dir_q[i]),
            .alt_a_i   (alt_a_q[i]),
            .alt_b_i   (alt_b_q[i]),
            .clear_i   (clear_d[i]),
            .pad_out_o (pad_out[i]),
            .pad_oe_o  (pad_oe[i]),
            .irq_o     (pin_irq[i])
        );
    end

    assign irq = irq_en & (|pin_irq);

    AST_GATE_KEEPS_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !wr_en && $stable(pad_in) && |pin_irq && (pin_irq & ~alt_a_q & alt_b_q) != '0)
        |=> |pin_irq); // R11

    AST_PLAIN_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_b_q == '0) |-> (pin_irq == '0))); // R2

endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_en = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pin_irq;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_en  (irq_en),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pin_irq (pin_irq),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset;
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pin_irq", pin_irq, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_plain_gpio;
        reg_write(3'd0, 8'h81);
        reg_write(3'd1, 8'hFE);
        check("R2 R12 oe", pad_oe, 8'h01);
        check("R2 out", pad_out & 8'h01, 8'h01);
        pad_in[6] = 1'b1; wait_n(4);
        pad_in[6] = 1'b0; wait_n(4);
        check("R2 input quiet", pin_irq, 8'h00);
        reg_write(3'd1, 8'hFF);
        check("R2 float", pad_oe, 8'h00);
    endtask

    task automatic t_configure;
        pad_in = 8'h1E;
        wait_n(4);
        reg_write(3'd0, 8'h0C);
        reg_write(3'd1, 8'hF9);
        reg_write(3'd2, 8'h1A);
        reg_write(3'd3, 8'h3E);
        wait_n(1);
        check("R10 oe", pad_oe, 8'h00);
        check("R10 out", pad_out, 8'h00);
        check("R10 quiet", pin_irq, 8'h00);
        irq_en = 1'b1;
    endtask

    task automatic t_level;
        pad_in[1] = 1'b0;
        wait_n(2);
        check("R3 early", pin_irq, 8'h00);
        wait_n(1);
        check("R3 asserted", pin_irq, 8'h02);
        check("R11 irq on", {7'd0, irq}, 8'h01);
        reg_write(3'd4, 8'h02);
        check("R5 clear ignored", pin_irq, 8'h02);
        pad_in[1] = 1'b1;
        wait_n(1);
        check("R5 still held", pin_irq, 8'h02);
        wait_n(1);
        check("R5 released", pin_irq, 8'h00);
    endtask

    task automatic t_level_glitch;
        int seen = 0;
        pad_in[1] = 1'b0;
        @(negedge clk);
        pad_in[1] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (pin_irq[1]) seen++;
        end
        check("R4 glitch", seen[7:0], 8'h00);
    endtask

    task automatic t_dual;
        pad_in[2] = 1'b0;
        wait_n(2);
        check("R6 fall early", pin_irq, 8'h00);
        wait_n(1);
        check("R6 fall", pin_irq, 8'h04);
        reg_write(3'd4, 8'hFB);
        check("R8 zero bit keeps", pin_irq, 8'h04);
        wait_n(3);
        check("R8 sticky", pin_irq, 8'h04);
        reg_write(3'd4, 8'h04);
        check("R8 cleared", pin_irq, 8'h00);
        pad_in[2] = 1'b1;
        wait_n(3);
        check("R6 rise", pin_irq, 8'h04);
        reg_write(3'd4, 8'h04);
        check("R8 cleared again", pin_irq, 8'h00);
    endtask

    task automatic t_single;
        pad_in[3] = 1'b0;
        wait_n(4);
        check("R7 rising pin ignores fall", pin_irq, 8'h00);
        pad_in[3] = 1'b1;
        wait_n(3);
        check("R7 rising", pin_irq, 8'h08);
        reg_write(3'd4, 8'h08);
        pad_in[4] = 1'b0;
        wait_n(3);
        check("R7 falling", pin_irq, 8'h10);
        reg_write(3'd4, 8'h10);
        pad_in[4] = 1'b1;
        wait_n(4);
        check("R7 falling pin ignores rise", pin_irq, 8'h00);
    endtask

    task automatic t_race;
        pad_in[2] = 1'b0;
        wait_n(3);
        check("R9 setup", pin_irq, 8'h04);
        pad_in[2] = 1'b1;
        wait_n(2);
        reg_write(3'd4, 8'h04);
        check("R9 edge wins", pin_irq, 8'h04);
        reg_write(3'd4, 8'h04);
        check("R9 then clear", pin_irq, 8'h00);
    endtask

    task automatic t_gate;
        pad_in[4] = 1'b0;
        wait_n(3);
        irq_en = 1'b0;
        wait_n(3);
        check("R11 gated", {7'd0, irq}, 8'h00);
        check("R11 pending kept", pin_irq, 8'h10);
        irq_en = 1'b1;
        wait_n(1);
        check("R11 ungated", {7'd0, irq}, 8'h01);
        reg_write(3'd4, 8'h10);
        check("R11 off", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_reserved;
        pad_in[5] = 1'b1;
        wait_n(4);
        pad_in[5] = 1'b0;
        wait_n(4);
        check("R10 unused setting quiet", pin_irq, 8'h00);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_plain_gpio();
        t_configure();
        t_level();
        t_level_glitch();
        t_dual();
        t_single();
        t_race();
        t_gate();
        t_reserved();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog got=00 exp=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule